// File: doc/BRIEF.md
# Positional Cube Calculator

This unit performs cube-calculus operations on product terms of functions whose inputs take several values and whose output is binary. A term is stored in positional form. Each input variable owns a field with one bit per value it can take, and a set bit means that value is allowed. A field of all ones leaves the variable unconstrained. A field of all zeros allows no value, so the whole term is empty. The layout is fixed by package parameters: one two-valued field, one three-valued field and two four-valued fields, 13 bits in total.

A request carries two operand cubes and an opcode, and is accepted with a valid/ready handshake. The unit can intersect the two cubes (bitwise AND per field) or merge them into their supercube (bitwise OR per field). It can also test cube A for emptiness, test whether A lies inside B, or count the minterms of A. The minterm count is the product of the number of allowed values in each field. This product is built one field per clock cycle. The result is held on the output side until the consumer takes it with its own valid/ready handshake. The unit offers no bitwise complement, because inverting the bits of a cube does not give the set complement of the term.

The controller is a three-state machine:
- `ST_IDLE` waits for a request.
- `ST_MUL` steps through the fields during a size request.
- `ST_DONE` presents the result.

It has five transitions:
- `IDLE→DONE`: a non-size request is accepted.
- `IDLE→MUL`: a size request is accepted.
- `MUL→MUL`: fields remain to be multiplied.
- `MUL→DONE`: the last field has been multiplied.
- `DONE→IDLE`: the consumer takes the result.

Top module: `pcn_cube_unit`

## Requirements
- R1: Field f occupies bits starting at the sum of the widths of fields 0..f-1, in the order widths 2, 3, 4, 4. Bit j of a field (counting from that field's least significant bit) stands for value j. A cube is empty exactly when at least one field is all zeros.
- R2: Opcode 0 (intersect) returns `out_cube` = A AND B, with `out_empty` giving the emptiness of that result. `out_inside` and `out_size` are 0.
- R3: Opcode 1 (merge) returns `out_cube` = A OR B, with `out_empty` giving the emptiness of that result. `out_inside` and `out_size` are 0.
- R4: Opcode 2 (empty test) returns `out_cube` = A and `out_empty` = emptiness of A. `out_inside` and `out_size` are 0.
- R5: Opcode 3 (containment) returns `out_cube` = A AND NOT B. `out_inside` is 1 exactly when every field of that value is zero. `out_empty` gives the emptiness of A, and `out_size` is 0.
- R6: Opcode 4 (size) returns `out_cube` = A, `out_empty` = emptiness of A and `out_size` = the product over all fields of the count of ones in the field. The size is 0 when A is empty. `out_inside` is 0.
- R7: A non-size request makes `out_valid` rise 1 cycle after the accepting clock edge. A size request makes it rise 5 cycles after the accepting edge (fields plus one).
- R8: `in_ready` is low from acceptance until the result is taken, so at most one request is in flight.
- R9: While `out_valid` is high and `out_ready` is low, all result ports hold their values. The cycle after a handshake, `out_valid` is low and `in_ready` is high.
- R10: Opcodes 5 to 7 are reserved. They complete with the 1-cycle latency and return all result ports as zero.
- R11: While `out_valid` is low, `out_cube`, `out_empty`, `out_inside` and `out_size` are zero. After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit can accept a request |
| in_op | input | 3 | Opcode (0 intersect, 1 merge, 2 empty, 3 inside, 4 size) |
| in_a | input | 13 | Operand cube A |
| in_b | input | 13 | Operand cube B |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_cube | output | 13 | Result cube |
| out_empty | output | 1 | Emptiness flag |
| out_inside | output | 1 | A lies inside B |
| out_size | output | 7 | Minterm count of A |

## Verification
The bound checker watches the handshake rules on every cycle:
- results stay stable under backpressure;
- the unit returns to idle after a handshake;
- result ports are zero while no result is offered;
- an empty flag always comes with a zero size;
- the latency is 1 cycle for non-size requests and fields-plus-one cycles for size requests, counted with a checker register.

Whether the cube values are correct can only be shown by the bench's scenarios. These compare the results against independently computed field-wise AND, OR, AND-NOT, emptiness and popcount products, for random cubes and for the corner cases. The corner cases are the full cube, single minterms, one empty field, equal operands and reserved opcodes.

// File: rtl/pcn_pkg.sv
package pcn_pkg;

    localparam int NF = 4;
    localparam int FW [0:NF-1] = '{2, 3, 4, 4};

    function automatic int f_off(input int i);
        int s;
        s = 0;
        for (int k = 0; k < i; k++) s += FW[k];
        return s;
    endfunction

    function automatic int f_maxw();
        int m;
        m = 0;
        for (int k = 0; k < NF; k++) if (FW[k] > m) m = FW[k];
        return m;
    endfunction

    function automatic int f_maxsz();
        int p;
        p = 1;
        for (int k = 0; k < NF; k++) p *= FW[k];
        return p;
    endfunction

    localparam int CW    = f_off(NF);
    localparam int MAXW  = f_maxw();
    localparam int MAXSZ = f_maxsz();
    localparam int SW    = $clog2(MAXSZ + 1);
    localparam int CNTW  = $clog2(MAXW + 1);
    localparam int IW    = (NF > 1) ? $clog2(NF) : 1;

    typedef enum logic [2:0] {
        OP_ISECT  = 3'd0,
        OP_MERGE  = 3'd1,
        OP_EMPTY  = 3'd2,
        OP_INSIDE = 3'd3,
        OP_SIZE   = 3'd4
    } op_e;

endpackage

// File: rtl/pcn_lane.sv
module pcn_lane #(
    parameter int W    = 4,
    parameter int CNTW = 3
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    f_and,
    output logic [W-1:0]    f_or,
    output logic [W-1:0]    f_anb,
    output logic            and_zero,
    output logic            or_zero,
    output logic            a_zero,
    output logic            anb_zero,
    output logic [CNTW-1:0] a_count
);

    always_comb begin
        f_and    = a & b;
        f_or     = a | b;
        f_anb    = a & ~b;
        and_zero = (f_and == '0);
        or_zero  = (f_or == '0);
        a_zero   = (a == '0);
        anb_zero = (f_anb == '0);
        a_count  = CNTW'($countones(a));
    end

endmodule

// File: rtl/pcn_size_acc.sv
module pcn_size_acc #(
    parameter int SW   = 7,
    parameter int CNTW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    input  logic [CNTW-1:0] factor,
    output logic [SW-1:0]   acc
);

    logic [SW-1:0] fac_ext;

    assign fac_ext = {{(SW-CNTW){1'b0}}, factor};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc <= '0;
        else if (clear) acc <= SW'(1);
        else if (step)  acc <= SW'(acc * fac_ext);
    end

endmodule

// File: rtl/pcn_cube_unit.sv
module pcn_cube_unit
    import pcn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [2:0]           in_op,
    input  logic [pcn_pkg::CW-1:0] in_a,
    input  logic [pcn_pkg::CW-1:0] in_b,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [pcn_pkg::CW-1:0] out_cube,
    output logic                 out_empty,
    output logic                 out_inside,
    output logic [pcn_pkg::SW-1:0] out_size
);

    typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_DONE} state_e;

    state_e        state_q, state_d;
    logic [2:0]    op_q;
    logic [CW-1:0] a_q, b_q;
    logic [IW-1:0] idx_q;

    logic          accept;
    logic          last_field;

    logic [CW-1:0] and_cube, or_cube, anb_cube;
    logic [NF-1:0] and_z, or_z, a_z, anb_z;
    logic [CNTW-1:0] cnt [NF];
    logic [CNTW-1:0] sel_cnt;
    logic [SW-1:0] size_acc;

    assign accept     = (state_q == ST_IDLE) && in_valid;
    assign last_field = (idx_q == IW'(NF - 1));
    assign sel_cnt    = cnt[idx_q];

    for (genvar g = 0; g < NF; g++) begin : g_lane
        localparam int OFF = f_off(g);
        localparam int W   = FW[g];
        pcn_lane #(.W(W), .CNTW(CNTW)) u_lane (
            .a        (a_q[OFF +: W]),
            .b        (b_q[OFF +: W]),
            .f_and    (and_cube[OFF +: W]),
            .f_or     (or_cube[OFF +: W]),
            .f_anb    (anb_cube[OFF +: W]),
            .and_zero (and_z[g]),
            .or_zero  (or_z[g]),
            .a_zero   (a_z[g]),
            .anb_zero (anb_z[g]),
            .a_count  (cnt[g])
        );
    end

    pcn_size_acc #(.SW(SW), .CNTW(CNTW)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .step   (state_q == ST_MUL),
        .factor (sel_cnt),
        .acc    (size_acc)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = (in_op == OP_SIZE) ? ST_MUL : ST_DONE;
            ST_MUL:  if (last_field) state_d = ST_DONE;
            ST_DONE: if (out_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and operand registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            a_q     <= '0;
            b_q     <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q  <= in_op;
                a_q   <= in_a;
                b_q   <= in_b;
                idx_q <= '0;
            end else if (state_q == ST_MUL) begin
                idx_q <= idx_q + IW'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        in_ready   = (state_q == ST_IDLE);
        out_valid  = (state_q == ST_DONE);
        out_cube   = '0;
        out_empty  = 1'b0;
        out_inside = 1'b0;
        out_size   = '0;
        if (state_q == ST_DONE) begin
            case (op_q)
                OP_ISECT: begin
                    out_cube  = and_cube;
                    out_empty = |and_z;
                end
                OP_MERGE: begin
                    out_cube  = or_cube;
                    out_empty = |or_z;
                end
                OP_EMPTY: begin
                    out_cube  = a_q;
                    out_empty = |a_z;
                end
                OP_INSIDE: begin
                    out_cube   = anb_cube;
                    out_empty  = |a_z;
                    out_inside = &anb_z;
                end
                OP_SIZE: begin
                    out_cube  = a_q;
                    out_empty = |a_z;
                    out_size  = size_acc;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pcn_cube_unit_chk.sv
module pcn_cube_unit_chk
    import pcn_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [2:0]    in_op,
    input logic          out_valid,
    input logic          out_ready,
    input logic [CW-1:0] out_cube,
    input logic          out_empty,
    input logic          out_inside,
    input logic [SW-1:0] out_size
);

    logic           pend_size;
    logic [7:0]     lat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_size <= 1'b0;
            lat_cnt   <= '0;
        end else if (in_valid && in_ready) begin
            pend_size <= (in_op == OP_SIZE);
            lat_cnt   <= '0;
        end else if (pend_size && !out_valid) begin
            lat_cnt <= lat_cnt + 8'd1;
        end else if (out_valid && out_ready) begin
            pend_size <= 1'b0;
        end
    end

    assert_size_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_size && out_valid) |-> (lat_cnt == 8'(NF)));

    assert_short_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op != OP_SIZE) |=> out_valid);

    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_cube) && $stable(out_empty)
                                       && $stable(out_inside) && $stable(out_size)));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (!out_valid && in_ready));

    assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_cube == '0 && !out_empty && !out_inside && out_size == '0));

    assert_empty_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_empty) |-> (out_size == '0));

    assert_size_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_size <= SW'(MAXSZ));

endmodule

bind pcn_cube_unit pcn_cube_unit_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_op      (in_op),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_cube   (out_cube),
    .out_empty  (out_empty),
    .out_inside (out_inside),
    .out_size   (out_size)
);

// File: tb/test_pcn_cube_unit.sv
module test_pcn_cube_unit;
    import pcn_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [2:0]    in_op = '0;
    logic [CW-1:0] in_a = '0;
    logic [CW-1:0] in_b = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [CW-1:0] out_cube;
    logic          out_empty;
    logic          out_inside;
    logic [SW-1:0] out_size;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcn_cube_unit i_pcn_cube_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_cube(out_cube), .out_empty(out_empty),
        .out_inside(out_inside), .out_size(out_size)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int fld(input logic [CW-1:0] c, input int f);
        int v;
        v = 0;
        for (int j = 0; j < FW[f]; j++) v |= int'(c[f_off(f) + j]) << j;
        return v;
    endfunction

    function automatic bit is_empty(input logic [CW-1:0] c);
        for (int f = 0; f < NF; f++) if (fld(c, f) == 0) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int cube_size(input logic [CW-1:0] c);
        int p;
        p = 1;
        for (int f = 0; f < NF; f++) p *= $countones(fld(c, f));
        return p;
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [CW-1:0] a,
                          input logic [CW-1:0] b, input bit bp);
        logic [CW-1:0] e_cube;
        bit e_empty, e_inside;
        int e_size, e_lat, lat;
        logic [CW-1:0] h_cube;
        e_cube = '0; e_empty = 0; e_inside = 0; e_size = 0;
        e_lat = (op == 3'd4) ? NF + 1 : 1;
        case (op)
            3'd0: begin e_cube = a & b; e_empty = is_empty(a & b); end  // R2
            3'd1: begin e_cube = a | b; e_empty = is_empty(a | b); end  // R3
            3'd2: begin e_cube = a; e_empty = is_empty(a); end          // R4
            3'd3: begin e_cube = a & ~b; e_empty = is_empty(a);         // R5
                        e_inside = ((a & ~b) == '0); end
            3'd4: begin e_cube = a; e_empty = is_empty(a);              // R6
                        e_size = cube_size(a); end
            default: ;                                                  // R10
        endcase
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; out_ready = !bp;
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R8 busy after accept", int'(in_ready), 0);
        lat = 1;
        while (!out_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == e_lat, "R7 latency", lat, e_lat);
        chk(out_cube == e_cube, (op > 4) ? "R10 cube" : "R2-5 cube", int'(out_cube), int'(e_cube));
        chk(out_empty == e_empty, "R1 empty flag", int'(out_empty), int'(e_empty));
        chk(out_inside == e_inside, "R5 inside flag", int'(out_inside), int'(e_inside));
        chk(int'(out_size) == e_size, "R6 size", int'(out_size), e_size);
        if (bp) begin
            h_cube = out_cube;
            repeat (2) @(negedge clk);
            chk(out_valid && out_cube == h_cube, "R9 hold", int'(out_cube), int'(h_cube));
            out_ready = 1'b1;
        end
        @(negedge clk);
        chk(!out_valid && in_ready, "R9 release", int'({out_valid, in_ready}), 1);
        chk(out_cube == '0 && out_size == '0, "R11 quiet outputs", int'(out_cube), 0);
    endtask

    function automatic logic [CW-1:0] rnd_cube();
        logic [CW-1:0] c;
        c = CW'($urandom);
        for (int f = 0; f < NF; f++)
            if ($urandom_range(0, 2) == 0)
                for (int j = 0; j < FW[f]; j++) c[f_off(f) + j] = 1'b1;
        return c;
    endfunction

    initial begin
        logic [CW-1:0] a, b, full, mint;
        void'($urandom(32'd4711));
        full = '1;
        mint = '0;
        for (int f = 0; f < NF; f++) mint[f_off(f)] = 1'b1;  // value 0 in every field
        #(CLK_PERIOD * 2 + 1);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R11 reset state",
            int'({in_ready, out_valid}), 2);
        rst_n = 1'b1;
        // directed corners
        run_op(3'd4, full, '0, 0);                            // R6 full cube = max size
        run_op(3'd4, mint, '0, 0);                            // R6 minterm size 1
        a = full; a[f_off(2) +: FW[2]] = '0;
        run_op(3'd4, a, '0, 1);                               // R6 empty field -> 0
        run_op(3'd2, a, '0, 0);                               // R4 empty
        run_op(3'd3, mint, full, 0);                          // R5 inside true
        run_op(3'd3, full, mint, 0);                          // R5 inside false
        run_op(3'd3, a, a, 0);                                // R5 equal operands
        run_op(3'd0, mint, ~mint, 0);                         // R2 disjoint -> empty
        run_op(3'd1, mint, ~mint, 1);                         // R3 merge -> full
        run_op(3'd6, full, full, 0);                          // R10 reserved
        run_op(3'd5, full, mint, 1);                          // R10 reserved
        // random mix
        for (int i = 0; i < 400; i++) begin
            a = rnd_cube();
            b = ($urandom_range(0, 3) == 0) ? (a | rnd_cube()) : rnd_cube();
            run_op(3'($urandom_range(0, 7)), a, b, $urandom_range(0, 3) == 0);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule